// File: doc/BRIEF.md
# Command-Word Sync Sequencer

This block produces the horizontal and vertical sync levels for a raster display from a stream of packed 32-bit command words, instead of using fixed timing counters. Each word carries a pin state for both sync lines, a 14-bit hold count and an action code. The hold count sets how long that pin state stays on the pins. A nonzero action code fires a single-cycle start-of-line pulse, which tells a pixel engine to begin a scanline.

Words enter through a valid/ready handshake into an internal eight-entry queue. Eight entries hold two scanlines of four words each. Software writes the words for every line of a frame in turn: pulse, back porch, visible region and front porch. The sequencer plays them back with cycle-exact spacing. When the queue runs dry the pins freeze at their last state and an underflow flag reports the gap.

Top module: `cmdSyncSequencer`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge), hsync and vsync are 1, lineStart is 0 and cmdReady is 1.
- R2: In a command word, bit 0 sets hsync and bit 1 sets vsync. Both pins take these bits together on the clock edge that takes the word from the queue, before any hold counting.
- R3: A word's pin state stays on the pins for exactly D + 6 clock cycles, where D is the unsigned delay field in bits 15:2. This holds for every D from 0 to 16383, provided the next word is already queued.
- R4: A word whose action field (bits 31:16) is 16'h0000 produces no lineStart pulse.
- R5: A word with any nonzero action field raises lineStart for exactly one cycle. The pulse lands in the fourth cycle of that word's pin state, three cycles after the pin update.
- R6: The queue holds 8 words and returns them in arrival order. cmdReady is low while it is full.
- R7: If a word's hold ends with the queue empty, the pins keep their state and underflow is 1. Underflow stays 1 until a word is written. That word takes effect on the pins one cycle after it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdWord | input | 32 | Command word: action[31:16], delay[15:2], vsync[1], hsync[0] |
| cmdValid | input | 1 | Command word offered |
| cmdReady | output | 1 | Queue can take a word |
| hsync | output | 1 | Horizontal sync level |
| vsync | output | 1 | Vertical sync level |
| lineStart | output | 1 | One-cycle start-of-line trigger |
| underflow | output | 1 | A word is needed and the queue is empty |

## Verification
The assertions check four things on every cycle: the pins move only on a fetch strobe, the trigger is never longer than one cycle, it never fires at the end of a hold, and the pins stay frozen while starved. Only the bench scenarios show the full D + 6 spacing for short, long and maximal delays. The same goes for the exact trigger offset, the fill depth at which cmdReady drops, in-order replay, and the one-cycle latency from a write during a stall to the new pin state.

// File: rtl/cmdSyncPkg.sv
package cmdSyncPkg;
  parameter int ACTION_W = 16;
  parameter int DELAY_W  = 14;

  typedef struct packed {
    logic [ACTION_W-1:0] action;
    logic [DELAY_W-1:0]  delay;
    logic                vsync;
    logic                hsync;
  } cmdWordT;

  localparam int WORD_W = $bits(cmdWordT);

  typedef struct packed {
    logic load;
    logic fire;
  } strobesT;
endpackage

// File: rtl/cmdSyncFifo.sv
module cmdSyncFifo
  import cmdSyncPkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    push,
  input  cmdWordT pushWord,
  input  logic    pop,
  output cmdWordT headWord,
  output logic    empty,
  output logic    full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  cmdWordT            store [DEPTH];
  logic [PTR_W-1:0]   wrPtr;
  logic [PTR_W-1:0]   rdPtr;
  logic [CNT_W-1:0]   count;

  assign empty    = (count == '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign headWord = store[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= pushWord;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_push_fill_R6: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/cmdSyncDatapath.sv
module cmdSyncDatapath
  import cmdSyncPkg::*;
#(
  parameter int OVERHEAD = 6,
  parameter int CNT_W    = DELAY_W + 1
) (
  input  logic    clk,
  input  logic    rst,
  input  strobesT strobe,
  input  cmdWordT word,
  output logic    hsync,
  output logic    vsync,
  output logic    lineStart,
  output logic    holdDone,
  output logic    actPending
);
  logic [CNT_W-1:0] holdCnt;

  assign holdDone = (holdCnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync      <= 1'b1;
      vsync      <= 1'b1;
      holdCnt    <= '0;
      actPending <= 1'b0;
      lineStart  <= 1'b0;
    end else begin
      lineStart <= strobe.fire;
      if (strobe.load) begin
        hsync      <= word.hsync;
        vsync      <= word.vsync;
        holdCnt    <= CNT_W'(word.delay) + CNT_W'(OVERHEAD - 1);
        actPending <= |word.action;
      end else if (!holdDone) begin
        holdCnt <= holdCnt - 1'b1;
      end
    end
  end

  assert_pins_stable_R3: assert property (@(posedge clk) disable iff (rst)
    !strobe.load |=> $stable({hsync, vsync}));
  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
    lineStart |=> !lineStart);
endmodule

// File: rtl/cmdSyncControl.sv
module cmdSyncControl
  import cmdSyncPkg::*;
#(
  parameter int TRIG_LAG = 3
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    holdDone,
  input  logic    actPending,
  input  logic    fifoEmpty,
  output strobesT strobe,
  output logic    underflow
);
  localparam int AGE_W = $clog2(TRIG_LAG + 1);

  logic [AGE_W-1:0] age;

  always_comb begin
    strobe.load = holdDone && !fifoEmpty;
    strobe.fire = actPending && (age == AGE_W'(TRIG_LAG - 1));
    underflow   = holdDone && fifoEmpty;
  end

  always_ff @(posedge clk) begin
    if (rst)                          age <= AGE_W'(TRIG_LAG);
    else if (strobe.load)             age <= '0;
    else if (age != AGE_W'(TRIG_LAG)) age <= age + 1'b1;
  end

  assert_fire_midhold_R5: assert property (@(posedge clk) disable iff (rst)
    strobe.fire |-> !holdDone);
endmodule

// File: rtl/cmdSyncSequencer.sv
module cmdSyncSequencer
  import cmdSyncPkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int OVERHEAD   = 6,
  parameter int TRIG_LAG   = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] cmdWord,
  input  logic        cmdValid,
  output logic        cmdReady,
  output logic        hsync,
  output logic        vsync,
  output logic        lineStart,
  output logic        underflow
);
  localparam int CNT_W = DELAY_W + 1;

  strobesT strobe;
  cmdWordT headWord;
  logic    fifoEmpty;
  logic    fifoFull;
  logic    holdDone;
  logic    actPending;

  assign cmdReady = !fifoFull;

  cmdSyncFifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
    .clk      (clk),
    .rst      (rst),
    .push     (cmdValid && !fifoFull),
    .pushWord (cmdWordT'(cmdWord)),
    .pop      (strobe.load),
    .headWord (headWord),
    .empty    (fifoEmpty),
    .full     (fifoFull)
  );

  cmdSyncControl #(.TRIG_LAG(TRIG_LAG)) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .holdDone   (holdDone),
    .actPending (actPending),
    .fifoEmpty  (fifoEmpty),
    .strobe     (strobe),
    .underflow  (underflow)
  );

  cmdSyncDatapath #(.OVERHEAD(OVERHEAD), .CNT_W(CNT_W)) i_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .word       (headWord),
    .hsync      (hsync),
    .vsync      (vsync),
    .lineStart  (lineStart),
    .holdDone   (holdDone),
    .actPending (actPending)
  );

  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (hsync && vsync && !lineStart));
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    underflow |=> $stable({hsync, vsync}));
endmodule

// File: tb/test_cmdSyncSequencer.sv
module test_cmdSyncSequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cmdWord = '0;
  logic        cmdValid = 1'b0;
  logic        cmdReady, hsync, vsync, lineStart, underflow;

  always #2.5 clk = ~clk;

  cmdSyncSequencer i_cmdSyncSequencer (
    .clk(clk), .rst(rst), .cmdWord(cmdWord), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .hsync(hsync), .vsync(vsync),
    .lineStart(lineStart), .underflow(underflow)
  );

  typedef struct { logic [1:0] pins; int len; int trig; } expT;
  expT expQ[$];

  int errors = 0;
  int checks = 0;
  int accepted = 0;
  logic [1:0] lastSent = 2'b11;
  logic [1:0] lastPins = 2'b11;
  bit inSeg = 0;
  int segLen, segTrig, nTrig;
  logic [1:0] segPins;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: queue a word and its expected segment
  task automatic sendWord(input logic [1:0] pins, input int delay, input logic [15:0] act);
    expT e;
    logic [1:0] p = pins;
    if (p == lastSent) p ^= 2'b01;
    lastSent = p;
    @(negedge clk);
    while (!cmdReady) begin cmdValid = 1'b0; @(negedge clk); end
    cmdValid = 1'b1;
    cmdWord = {act, 14'(delay), p};
    @(posedge clk);
    accepted++;
    e.pins = p; e.len = delay + 6; e.trig = (act != 0) ? 3 : -1;
    expQ.push_back(e);
  endtask

  task automatic closeSeg();
    expT e;
    if (expQ.size() == 0) begin
      check(0, "R6", "unexpected segment", segLen, 0);
      return;
    end
    e = expQ.pop_front();
    check(segPins == e.pins, "R2", "pins", int'(segPins), int'(e.pins));
    check(segLen == e.len, "R3", "hold length", segLen, e.len);
    if (e.trig < 0) check(segTrig < 0, "R4", "trigger offset", segTrig, e.trig);
    else begin
      check(segTrig == e.trig, "R5", "trigger offset", segTrig, e.trig);
      check(nTrig == 1, "R5", "trigger cycles", nTrig, 1);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst) begin
      inSeg = 0;
      lastPins = 2'b11;
    end else begin
      if ({vsync, hsync} != lastPins) begin
        if (inSeg) closeSeg();
        inSeg = 1; segLen = 0; segTrig = -1; nTrig = 0;
        segPins = {vsync, hsync};
      end
      lastPins = {vsync, hsync};
      if (inSeg) begin
        if (lineStart) begin
          if (segTrig < 0) segTrig = segLen;
          nTrig++;
        end
        segLen++;
        if (underflow) begin closeSeg(); inSeg = 0; end
      end else if (lineStart) begin
        check(0, "R4", "stray lineStart", 1, 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(0, "R3", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [1:0] oldPins;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(hsync == 1'b1, "R1", "hsync after reset", int'(hsync), 1);
    check(vsync == 1'b1, "R1", "vsync after reset", int'(vsync), 1);
    check(lineStart == 1'b0, "R1", "lineStart after reset", int'(lineStart), 0);
    check(cmdReady == 1'b1, "R1", "cmdReady after reset", int'(cmdReady), 1);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(underflow == 1'b1, "R7", "underflow when starved", int'(underflow), 1);
    check({vsync, hsync} == 2'b11, "R7", "pins held when starved", int'({vsync, hsync}), 3);

    // burst fill: first word holds long so the queue fills
    accepted = 0;
    sendWord(2'b10, 100, 16'h0000);
    sendWord(2'b01, 0,   16'h0001);
    sendWord(2'b00, 1,   16'h0000);
    sendWord(2'b10, 5,   16'hFFFF);
    sendWord(2'b11, 3,   16'h0000);
    sendWord(2'b01, 0,   16'h8000);
    sendWord(2'b00, 2,   16'h0000);
    sendWord(2'b10, 7,   16'h0001);
    sendWord(2'b11, 4,   16'h0000);
    @(negedge clk);
    check(cmdReady == 1'b0, "R6", "cmdReady when full", int'(cmdReady), 0);
    check(accepted == 9, "R6", "words accepted before full", accepted, 9);
    sendWord(2'b01, 0, 16'h0000);
    @(negedge clk); cmdValid = 1'b0;
    while (expQ.size() != 0) @(negedge clk);

    // stall then single write: latency of one cycle
    repeat (5) @(negedge clk);
    check(underflow == 1'b1, "R7", "underflow after drain", int'(underflow), 1);
    oldPins = {vsync, hsync};
    sendWord(2'b10, 2, 16'h0001);
    @(negedge clk); cmdValid = 1'b0;
    check(underflow == 1'b0, "R7", "underflow cleared by write", int'(underflow), 0);
    check({vsync, hsync} == oldPins, "R7", "pins one cycle after write",
          int'({vsync, hsync}), int'(oldPins));
    @(negedge clk);
    check({vsync, hsync} == lastSent, "R7", "pins two cycles after write",
          int'({vsync, hsync}), int'(lastSent));
    while (expQ.size() != 0) @(negedge clk);

    // maximal delay followed by a short one
    sendWord(2'b01, 16383, 16'h0002);
    sendWord(2'b00, 0, 16'h0000);
    @(negedge clk); cmdValid = 1'b0;
    while (expQ.size() != 0) @(negedge clk);

    // one scanline of four words
    sendWord(2'b10, 474,  16'h0000);
    sendWord(2'b11, 223,  16'h0000);
    sendWord(2'b11, 3205, 16'h0004);
    sendWord(2'b11, 74,   16'h0000);
    @(negedge clk); cmdValid = 1'b0;
    while (expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule